// File: doc/BRIEF.md
# Phase Tag Unwrap and Error Generator

This block sits after a phase-tagging front end and produces a continuous phase error for one reference channel. Each incoming item pairs a channel number with a 22-bit phase tag that wraps around. The block keeps only the items whose channel matches a reference number. That number is captured when `init` is asserted. Every other item is consumed and thrown away.

For each kept tag the block does the following in order:
- It extends the tag with a running wrap offset. The offset grows by 2^22 whenever the tag is smaller than the previous kept tag.
- It subtracts a setpoint, which is a ramp that advances by 2^14 per kept sample.
- It emits the difference as a signed 32-bit error, together with a sample index.

Offset and setpoint are kept bounded. Once the offset passes 100,000,000, both are reduced by that amount. Filtering and lock detection are done downstream.

Both the input and the output are valid/ready streams. The output is a single register stage. An item is taken from the input only when that register is empty or is being drained in the same cycle, so back-pressure on `out_ready` propagates to `in_ready` without any loss. An output held while `out_ready` is low keeps its values unchanged.

Top module: `phase_unwrap_err`

## Requirements
- R1: An input item whose channel differs from the captured reference number is consumed when `in_ready` is high. It produces no output and leaves offset, setpoint, previous tag and index unchanged.
- R2: After `init`, the first kept tag gives an error equal to the tag itself, with index 0.
- R3: When the previous kept tag is strictly greater than the current tag, the wrap offset grows by 2^22 before the error is formed. An equal or larger tag adds nothing.
- R4: The error is (tag + wrap offset) − setpoint, using the setpoint from before this sample. After each kept sample the setpoint grows by 2^14 and the tag becomes the previous tag.
- R5: When the updated wrap offset is greater than 100,000,000, the stored offset and the stored setpoint are both reduced by 100,000,000. The error sequence stays continuous across this rebase.
- R6: The index counts kept samples from 0 after `init` and wraps at 2^IDX_W.
- R7: The result of a kept sample is presented on the output in the cycle after acceptance. While `out_valid` is high and `out_ready` is low, `out_err` and `out_idx` hold their values.
- R8: `in_ready` is high exactly when `init` is low and the output register is empty or being drained (`out_ready` high).
- R9: `init` clears offset, setpoint, previous tag, index and any pending output, and captures `ref_id` as the reference number.
- R10: After reset, `out_valid` is low and `in_ready` is high, and the reference number is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Synchronous restart; captures `ref_id` |
| ref_id | input | CHAN_W | Reference channel number, sampled while `init` is high |
| in_valid | input | 1 | Input item present |
| in_ready | output | 1 | Input item taken this cycle if `in_valid` |
| in_chan | input | CHAN_W | Channel number of the item |
| in_tag | input | TAG_W | Wrapping phase tag |
| out_valid | output | 1 | Error result present |
| out_ready | input | 1 | Downstream takes the result |
| out_err | output | DATA_W | Signed phase error |
| out_idx | output | IDX_W | Index of the sample |

## Verification
The bench targets the following corner cases:
- **Wrap edge.** Tags going backwards, and tags repeating the previous value. A design using `>=` would add a spurious 2^22 on a repeated tag.
- **Rebase.** A long run of alternating wraps crosses the rebase bound. A design that rebased only the offset or only the setpoint would shift the error by 100,000,000.
- **Foreign-channel tags.** These are interleaved with kept ones. A design that let them update the previous tag would miss or invent wraps.
- **Back-pressure and `init`.** Stalled outputs, and `init` while a result is pending. A design that dropped or duplicated a result under stall, or kept stale state, would leave the scoreboard out of order.

// File: rtl/pue_pkg.sv
package pue_pkg;
  localparam int TAG_W_DEF   = 22;
  localparam int DATA_W_DEF  = 32;
  localparam int STEP_LOG2   = 14;
  localparam int REBASE_BND  = 100000000;
endpackage

// File: rtl/pue_unwrap.sv
module pue_unwrap #(
  parameter int TAG_W  = pue_pkg::TAG_W_DEF,
  parameter int DATA_W = pue_pkg::DATA_W_DEF,
  parameter int BOUND  = pue_pkg::REBASE_BND
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     init,
  input  logic                     acc,
  input  logic [TAG_W-1:0]         tag,
  output logic signed [DATA_W-1:0] off_upd,
  output logic                     rebase
);
  localparam logic signed [DATA_W-1:0] WRAP_INC = DATA_W'(1) <<< TAG_W;
  localparam logic signed [DATA_W-1:0] BND      = DATA_W'(BOUND);

  logic [TAG_W-1:0]         prev_q;
  logic signed [DATA_W-1:0] off_q;
  logic                     wrapped;

  assign wrapped = prev_q > tag;
  assign off_upd = wrapped ? off_q + WRAP_INC : off_q;
  assign rebase  = acc && (off_upd > BND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      off_q  <= '0;
    end else if (init) begin
      prev_q <= '0;
      off_q  <= '0;
    end else if (acc) begin
      prev_q <= tag;
      off_q  <= rebase ? off_upd - BND : off_upd;
    end
  end

  AST_OFF_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    off_q <= BND); // R5
  AST_WRAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !init) |=> (off_q == $past(off_q)) ||
                       (off_q == $past(off_q) + WRAP_INC) ||
                       (off_q == $past(off_q) + WRAP_INC - BND)); // R3
  AST_INIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (off_q == 0) && (prev_q == 0)); // R9
endmodule

// File: rtl/pue_setpoint.sv
module pue_setpoint #(
  parameter int DATA_W = pue_pkg::DATA_W_DEF,
  parameter int BOUND  = pue_pkg::REBASE_BND
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     init,
  input  logic                     acc,
  input  logic                     rebase,
  output logic signed [DATA_W-1:0] sp
);
  localparam logic signed [DATA_W-1:0] STEP = DATA_W'(1) <<< pue_pkg::STEP_LOG2;
  localparam logic signed [DATA_W-1:0] BND  = DATA_W'(BOUND);

  logic signed [DATA_W-1:0] sp_q;
  assign sp = sp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sp_q <= '0;
    else if (init)   sp_q <= '0;
    else if (acc)    sp_q <= rebase ? sp_q + STEP - BND : sp_q + STEP;
  end

  AST_RAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !init) |=> (sp_q == $past(sp_q) + STEP) ||
                       (sp_q == $past(sp_q) + STEP - BND)); // R4
endmodule

// File: rtl/pue_outreg.sv
module pue_outreg #(
  parameter int DATA_W = pue_pkg::DATA_W_DEF,
  parameter int IDX_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     init,
  input  logic                     acc,
  input  logic signed [DATA_W-1:0] err_in,
  input  logic                     out_ready,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_err,
  output logic [IDX_W-1:0]         out_idx
);
  logic [IDX_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_err   <= '0;
      out_idx   <= '0;
      cnt_q     <= '0;
    end else if (init) begin
      out_valid <= 1'b0;
      cnt_q     <= '0;
    end else if (acc) begin
      out_valid <= 1'b1;
      out_err   <= err_in;
      out_idx   <= cnt_q;
      cnt_q     <= cnt_q + 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !init) |=>
      out_valid && $stable(out_err) && $stable(out_idx)); // R7
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !init) |=> cnt_q == $past(cnt_q) + 1'b1); // R6
endmodule

// File: rtl/phase_unwrap_err.sv
module phase_unwrap_err #(
  parameter int CHAN_W = 5,
  parameter int TAG_W  = pue_pkg::TAG_W_DEF,
  parameter int DATA_W = pue_pkg::DATA_W_DEF,
  parameter int IDX_W  = 16,
  parameter int BOUND  = pue_pkg::REBASE_BND
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     init,
  input  logic [CHAN_W-1:0]        ref_id,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [CHAN_W-1:0]        in_chan,
  input  logic [TAG_W-1:0]         in_tag,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [DATA_W-1:0] out_err,
  output logic [IDX_W-1:0]         out_idx
);
  logic [CHAN_W-1:0]        ref_q;
  logic                     acc;
  logic                     rebase;
  logic signed [DATA_W-1:0] off_upd;
  logic signed [DATA_W-1:0] sp;
  logic signed [DATA_W-1:0] err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ref_q <= '0;
    else if (init) ref_q <= ref_id;
  end

  assign in_ready = !init && (!out_valid || out_ready);
  assign acc      = in_valid && in_ready && (in_chan == ref_q);
  assign err      = $signed(DATA_W'(in_tag)) + off_upd - sp;

  pue_unwrap #(.TAG_W(TAG_W), .DATA_W(DATA_W), .BOUND(BOUND)) u_unwrap (
    .clk(clk), .rst_n(rst_n), .init(init), .acc(acc), .tag(in_tag),
    .off_upd(off_upd), .rebase(rebase));

  pue_setpoint #(.DATA_W(DATA_W), .BOUND(BOUND)) u_setpoint (
    .clk(clk), .rst_n(rst_n), .init(init), .acc(acc), .rebase(rebase), .sp(sp));

  pue_outreg #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_outreg (
    .clk(clk), .rst_n(rst_n), .init(init), .acc(acc), .err_in(err),
    .out_ready(out_ready), .out_valid(out_valid), .out_err(out_err),
    .out_idx(out_idx));

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid); // R7
  AST_FOREIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_chan != ref_q && !out_valid) |=> !out_valid); // R1
endmodule

// File: tb/phase_unwrap_err_test.sv
module phase_unwrap_err_test;
  localparam int PERIOD = 10;
  localparam int IDXW   = 6;
  localparam longint BND = 100000000;

  logic clk = 0, rst_n = 0, init = 0;
  logic [4:0] ref_id = 0, in_chan = 0;
  logic in_valid = 0, out_ready = 1, bp_en = 0;
  logic [21:0] in_tag = 0;
  logic in_ready, out_valid;
  logic signed [31:0] out_err;
  logic [IDXW-1:0] out_idx;

  int checks = 0, errors = 0, cyc = 0;
  longint m_off, m_sp, m_prev, m_idx;
  int m_ref;
  longint q_err[$];
  longint q_idx[$];

  phase_unwrap_err #(.IDX_W(IDXW)) uut (
    .clk(clk), .rst_n(rst_n), .init(init), .ref_id(ref_id),
    .in_valid(in_valid), .in_ready(in_ready), .in_chan(in_chan), .in_tag(in_tag),
    .out_valid(out_valid), .out_ready(out_ready), .out_err(out_err), .out_idx(out_idx));

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (bp_en) out_ready = (cyc % 3) != 0;
  end

  // monitor: pops expected items on each output handshake
  initial forever begin
    @(negedge clk); #1;
    if (out_valid && out_ready) begin
      if (q_err.size() == 0) chk("R1 unexpected output", 1, 0);
      else begin
        chk("R4 error", longint'(out_err), q_err.pop_front());
        chk("R6 index", longint'(out_idx), q_idx.pop_front());
      end
    end
  end

  task automatic send(int ch, longint tag);
    longint o;
    @(negedge clk);
    in_valid = 1; in_chan = ch[4:0]; in_tag = tag[21:0];
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    if (ch == m_ref) begin
      o = m_off + ((m_prev > tag) ? (64'd1 << 22) : 0);
      q_err.push_back(longint'(32'(tag + o - m_sp)));
      q_idx.push_back(m_idx % (1 << IDXW));
      m_sp += 16384;
      if (o > BND) begin o -= BND; m_sp -= BND; end
      m_off = o; m_prev = tag; m_idx++;
    end
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic drain();
    int n = 0;
    while (q_err.size() != 0 && n < 2000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
    chk("R7 drained", q_err.size(), 0);
  endtask

  task automatic do_init(int r);
    @(negedge clk);
    init = 1; ref_id = r[4:0];
    #1; chk("R8 in_ready low in init", in_ready, 0);
    @(negedge clk);
    init = 0;
    q_err.delete(); q_idx.delete();
    m_off = 0; m_sp = 0; m_prev = 0; m_idx = 0; m_ref = r;
    #1; chk("R9 no pending output after init", out_valid, 0);
  endtask

  initial begin
    #(PERIOD*150000);
    chk("watchdog expired", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    m_off = 0; m_sp = 0; m_prev = 0; m_idx = 0; m_ref = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R10 out_valid after reset", out_valid, 0);
    chk("R10 in_ready after reset", in_ready, 1);
    send(0, 500);                      // R10 reference number 0
    drain();

    do_init(3);
    send(3, 12345);                    // R2 error equals tag, index 0
    for (int i = 1; i < 5; i++) send(3, 12345 + i*16384); // R4 constant error
    send(3, 12345 + 4*16384);          // R3 equal tag: no wrap
    drain();

    send(5, 0);                        // R1 foreign tag ignored
    repeat (3) @(negedge clk);
    #1; chk("R1 no output for foreign tag", out_valid, 0);
    send(3, 200000);                   // R1 previous tag untouched

    send(3, 4194000);
    send(7, 4194300);                  // R1 interleaved foreign
    send(3, 50);                       // R3 wrap
    drain();

    bp_en = 1;
    for (int i = 0; i < 60; i++) send(3, (i % 2 == 0) ? 4000000 : 100); // R5 R6
    drain();
    bp_en = 0; out_ready = 1;

    @(negedge clk); out_ready = 0;     // R7 stall
    send(3, 321);
    repeat (3) @(negedge clk);
    #1;
    chk("R7 held under stall", out_valid, 1);
    chk("R8 in_ready low under stall", in_ready, 0);
    @(negedge clk); out_ready = 1;
    drain();

    @(negedge clk); out_ready = 0;     // R9 pending output dropped by init
    send(3, 999);
    do_init(9);
    @(negedge clk); out_ready = 1;
    send(3, 1000);                     // R9 old reference now foreign
    send(9, 777);                      // R9 restart: error 777, index 0
    send(9, 777 + 16384);
    drain();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule